// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a two-wire serial bus slave that holds a file of 21 eight-bit configuration registers. The host reaches it only through whole-block transfers, and every transfer begins at register 0. There is no register pointer for the host to set. To update a setting near the end of the file, the host streams all the lower registers again in front of it.

A write transfer works as follows. After the address byte, the host sends two header bytes: a command code and a byte count. The slave acknowledges both and throws their values away. The data bytes that follow land in registers 0, 1, 2 and upward. The host may stop after any whole byte, and everything already received stays in place.

A read transfer works as follows. The slave first sends a length byte, which is the value held in register 8. It then sends register 0 up to the register whose index equals that value. Two register pairs, 11/12 and 13/14, are committed as a unit: a pair is loaded only when both of its bytes arrive in the same transfer.

The bus lines are sampled on a fast system clock. The slave drives the data line only through an open-drain enable.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, the register file holds these values: reg 0 = 00h, regs 1 to 5 = FFh, reg 6 = 07h, reg 7 = 22h, reg 8 = 08h, reg 9 = 10h, regs 10 to 20 = 00h. `cfg_o[8*i+7:8*i]` is register i.
- R2: Only the 8-bit address bytes D2h (write) and D3h (read) are acknowledged. After any other address byte, the slave leaves SDA released for the rest of the transfer and no register changes.
- R3: In a write, the first two bytes after the address are acknowledged and discarded. Each following data byte k (k = 0, 1, 2, ...) is written to register k. Bits are sent most significant first.
- R4: A stop after any complete data byte ends the write, and all bytes already acknowledged stay stored.
- R5: Registers 11/12 change only when both bytes are written in one transfer, and the same holds for 13/14. If only the lower byte of a pair arrives, neither register of that pair changes.
- R6: A read returns first the value L of register 8, then registers 0 through L in order. Any byte the host requests after register L reads FFh, because SDA stays released.
- R7: Register 7 always reads {001b, revision 00010b} = 22h. Registers 19 and 20 always read 00h. Writes to any of these three have no effect.
- R8: A start or a stop in the middle of a byte abandons the transfer, and the partial byte is not stored. After a start the slave accepts a new address at once.
- R9: When the host answers a read byte with NACK, the slave releases SDA and keeps it released until the next start or stop.
- R10: Write data bytes aimed at indices above 20 are acknowledged and discarded. When L exceeds 20, read indices 21 through L return 00h.
- R11: The slave pulls SDA low for the acknowledge bit of each byte it accepts: a matching address, a header byte, or a data byte. SDA changes only after SCL has been seen low, or on a start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| cfg_o | output | 168 | Register file contents, register i in bits 8*i+7 to 8*i |

## Verification
The hardest state to reach from the ports is a pair whose lower byte has been staged but not yet committed. Reaching it takes a transfer that ends exactly between the two bytes of a pair. The stimulus writes blocks of 12, 14 and 21 data bytes in turn, so that each pair is in turn abandoned after its lower byte, committed while the other pair is abandoned, and committed in full. Aborts in the middle of a byte are made by sending only part of a byte's bits before a stop or a repeated start. Register indices above 20 are reached by first writing a length above 20 into register 8 and then reading past the end of the file.

// File: rtl/cfgs_pkg.sv
// Package: types shared by the configuration slave.
// Assumes: nothing beyond IEEE 1800-2017.
package cfgs_pkg;

    // States of the bus transfer sequencer
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a start
        ST_ADDR,    // shifting in the address byte
        ST_AACK,    // acknowledging a matching address
        ST_WDATA,   // shifting in a header or data byte
        ST_WACK,    // acknowledging a received byte
        ST_RDATA,   // shifting out a byte
        ST_RACK,    // sampling the host acknowledge
        ST_IGNORE   // bus released until the next start or stop
    } bus_st_e;

endpackage

// File: rtl/cfgs_line_sync.sv
// Module: cfgs_line_sync
// Brings SCL and SDA into the clk domain through a synchronizer chain
// SYNC_STAGES deep, then reports SCL edges and start/stop conditions.
// Assumes: clk is well above the bus bit rate, so every bus phase spans
// several clk cycles. Idle lines reset to high.
module cfgs_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_p;
    logic [DEPTH-1:0] sda_p;

    // Shift both lines through the synchronizer plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[DEPTH-2:0], scl_i};
            sda_p <= {sda_p[DEPTH-2:0], sda_i};
        end
    end

    logic scl_now, scl_was, sda_now, sda_was;
    assign scl_now = scl_p[DEPTH-2];
    assign scl_was = scl_p[DEPTH-1];
    assign sda_now = sda_p[DEPTH-2];
    assign sda_was = sda_p[DEPTH-1];

    assign sda_q     = sda_now;
    assign scl_rise  = scl_now & ~scl_was;
    assign scl_fall  = ~scl_now & scl_was;
    assign start_det = scl_now & scl_was & sda_was & ~sda_now;
    assign stop_det  = scl_now & scl_was & ~sda_was & sda_now;

endmodule

// File: rtl/cfgs_regfile.sv
// Module: cfgs_regfile
// Holds the configuration registers with their reset values. It has a
// fixed identification register, two reserved registers that read zero,
// and two register pairs whose lower byte is staged until the upper byte
// of the same transfer arrives.
// Assumes: write indices arrive in rising order within a transfer, and
// xfer_end pulses on every start or stop.
module cfgs_regfile #(
    parameter int         NREG      = 21,
    parameter logic [2:0] VENDOR_ID = 3'b001,
    parameter logic [4:0] REV_ID    = 5'b00010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_idx,
    input  logic [7:0]      wr_data,
    input  logic            xfer_end,
    input  logic [7:0]      rd_idx,
    output logic [7:0]      rd_data,
    output logic [7:0]      len_q,
    output logic [NREG*8-1:0] cfg_o
);
    localparam int ID_IDX    = 7;
    localparam int LEN_IDX   = 8;
    localparam int PAIR_BASE = 11;
    localparam int NPAIR     = 2;
    localparam int RSV_LO    = 19;

    // Power-on value of a plain read/write register
    function automatic logic [7:0] dflt(input int i);
        if (i >= 1 && i <= 5) return 8'hFF;
        if (i == 6)           return 8'h07;
        if (i == LEN_IDX)     return 8'h08;
        if (i == 9)           return 8'h10;
        return 8'h00;
    endfunction

    logic [NPAIR-1:0] pend;
    logic [7:0]       stage [NPAIR];

    // Stage the lower byte of each pair and forget it at transfer end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            for (int p = 0; p < NPAIR; p++) stage[p] <= 8'h00;
        end else if (xfer_end) begin
            pend <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NPAIR; p++) begin
                if (wr_idx == 8'(PAIR_BASE + 2*p)) begin
                    pend[p]  <= 1'b1;
                    stage[p] <= wr_data;
                end else if (wr_idx == 8'(PAIR_BASE + 2*p + 1)) begin
                    pend[p]  <= 1'b0;
                end
            end
        end
    end

    for (genvar gi = 0; gi < NREG; gi++) begin : g_slot
        logic [7:0] q;
        if (gi == ID_IDX) begin : g_id
            assign q = {VENDOR_ID, REV_ID};
        end else if (gi >= RSV_LO) begin : g_rsv
            assign q = 8'h00;
        end else if (gi >= PAIR_BASE && gi < PAIR_BASE + 2*NPAIR
                     && ((gi - PAIR_BASE) % 2) == 0) begin : g_lo
            localparam int P = (gi - PAIR_BASE) / 2;
            // Lower pair byte: loads its staged value with the upper byte
            always_ff @(posedge clk) begin
                if (!rst_n) q <= dflt(gi);
                else if (wr_en && wr_idx == 8'(gi + 1) && pend[P]) q <= stage[P];
            end
        end else if (gi >= PAIR_BASE && gi < PAIR_BASE + 2*NPAIR) begin : g_hi
            localparam int P = (gi - PAIR_BASE) / 2;
            // Upper pair byte: loads only when its lower byte is staged
            always_ff @(posedge clk) begin
                if (!rst_n) q <= dflt(gi);
                else if (wr_en && wr_idx == 8'(gi) && pend[P]) q <= wr_data;
            end
        end else begin : g_rw
            // Plain register: loads on a write to its index
            always_ff @(posedge clk) begin
                if (!rst_n) q <= dflt(gi);
                else if (wr_en && wr_idx == 8'(gi)) q <= wr_data;
            end
        end
        assign cfg_o[gi*8 +: 8] = q;
    end

    // Read mux: indices past the file read zero
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == 8'(i)) rd_data = cfg_o[i*8 +: 8];
    end

    assign len_q = cfg_o[LEN_IDX*8 +: 8];

    for (genvar gp = 0; gp < NPAIR; gp++) begin : g_pair_chk
        localparam int LO = PAIR_BASE + 2*gp;
        AST_PAIR_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == 8'(LO)) |=> $stable(cfg_o[LO*8 +: 8])); // R5
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 8'(RSV_LO)) |=> (rd_idx != 8'(RSV_LO) || rd_data == 8'h00)); // R7

endmodule

// File: rtl/cfgs_bus_fsm.sv
// Module: cfgs_bus_fsm
// Runs one block transfer at a time. It shifts in the address, header and
// data bytes, acknowledges them, and shifts out the length byte and the
// register bytes. A start or stop at any point restarts or ends the
// transfer.
// Assumes: inputs come from cfgs_line_sync. SDA is sampled on SCL rise
// and changed only after SCL fall.
module cfgs_bus_fsm
    import cfgs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_q,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    input  logic [7:0] len_q,
    output logic [7:0] rd_idx,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       xfer_end,
    output logic       sda_oe
);
    localparam int HDR_BYTES = 2;

    bus_st_e    state;
    logic [2:0] bcnt;
    logic       full;
    logic [7:0] shreg;
    logic [7:0] pos;
    logic [7:0] txb;
    logic       hack;

    logic [7:0] pos_inc;
    logic [7:0] next_tx;
    assign pos_inc = (pos == 8'hFF) ? pos : pos + 8'd1;
    assign rd_idx  = pos;
    assign next_tx = (pos > len_q) ? 8'hFF : rd_data;

    // A data byte is written when its eighth bit is followed by SCL low
    assign wr_en    = (state == ST_WDATA) && scl_fall && full && (pos >= 8'(HDR_BYTES));
    assign wr_idx   = pos - 8'(HDR_BYTES);
    assign wr_data  = shreg;
    assign xfer_end = start_det | stop_det;

    // Transfer sequencer: start/stop first, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            bcnt  <= '0;
            full  <= 1'b0;
            shreg <= '0;
            pos   <= '0;
            txb   <= 8'hFF;
            hack  <= 1'b0;
        end else if (start_det) begin
            state <= ST_ADDR;
            bcnt  <= '0;
            full  <= 1'b0;
        end else if (stop_det) begin
            state <= ST_IDLE;
            full  <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_q};
                        bcnt  <= bcnt + 3'd1;
                        if (bcnt == 3'd7) full <= 1'b1;
                    end else if (scl_fall && full) begin
                        full <= 1'b0;
                        if (state == ST_ADDR) begin
                            state <= (shreg[7:1] == DEV_ADDR) ? ST_AACK : ST_IGNORE;
                        end else begin
                            state <= ST_WACK;
                            pos   <= pos_inc;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        bcnt <= '0;
                        pos  <= '0;
                        if (shreg[0]) begin
                            state <= ST_RDATA;
                            txb   <= len_q;
                        end else begin
                            state <= ST_WDATA;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        state <= ST_WDATA;
                        bcnt  <= '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        txb  <= {txb[6:0], 1'b1};
                        bcnt <= bcnt + 3'd1;
                        if (bcnt == 3'd7) state <= ST_RACK;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        hack <= ~sda_q;
                    end else if (scl_fall) begin
                        if (hack) begin
                            state <= ST_RDATA;
                            txb   <= next_tx;
                            pos   <= pos_inc;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Open-drain drive: acknowledges and zero bits of the outgoing byte
    always_comb begin
        case (state)
            ST_AACK, ST_WACK: sda_oe = 1'b1;
            ST_RDATA:         sda_oe = ~txb[7];
            default:          sda_oe = 1'b0;
        endcase
    end

    AST_START_ENTERS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bcnt == 3'd0 && !sda_oe)); // R8

    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe)); // R8

    AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_fall && !hack && !start_det && !stop_det) |=> !sda_oe); // R9

    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R11

    AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && full && shreg[7:1] == DEV_ADDR && !start_det && !stop_det)
        |=> sda_oe); // R2

endmodule

// File: rtl/smb_cfg_slave.sv
// Module: smb_cfg_slave (top)
// Configuration register slave on a two-wire bus that uses whole-block
// transfers. It connects the line synchronizer, the transfer sequencer
// and the register file.
// Assumes: the pads are open drain. sda_oe_o = 1 pulls SDA low.
module smb_cfg_slave #(
    parameter int         NREG        = 21,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [2:0] VENDOR_ID   = 3'b001,
    parameter logic [4:0] REV_ID      = 5'b00010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] cfg_o
);
    logic       sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_idx, rd_data, len_q;
    logic       wr_en, xfer_end;
    logic [7:0] wr_idx, wr_data;

    cfgs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgs_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .len_q     (len_q),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .xfer_end  (xfer_end),
        .sda_oe    (sda_oe_o)
    );

    cfgs_regfile #(
        .NREG      (NREG),
        .VENDOR_ID (VENDOR_ID),
        .REV_ID    (REV_ID)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .xfer_end (xfer_end),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .len_q    (len_q),
        .cfg_o    (cfg_o)
    );

endmodule

// File: tb/smb_cfg_slave_tb.sv
// Bench for smb_cfg_slave. A behavioural model of the register file
// (integer indices, staged pairs) is compared with cfg_o on every clock
// outside byte boundaries. Every read byte and acknowledge bit is
// checked as well.
module smb_cfg_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;   // clk cycles per quarter bus bit
    localparam int NREG       = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] cfg;
    wire  sda_bus = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_cfg_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .cfg_o    (cfg)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;

    logic [7:0] mreg [NREG];
    bit         mpend [2];
    logic [7:0] mstage [2];
    logic [7:0] wbuf [32];

    // Reset values as stated in R1 and R7
    task automatic mdl_init();
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
        for (int i = 1; i <= 5; i++) mreg[i] = 8'hFF;
        mreg[6] = 8'h07; mreg[7] = 8'h22; mreg[8] = 8'h08; mreg[9] = 8'h10;
        mpend[0] = 1'b0; mpend[1] = 1'b0;
    endtask

    function automatic logic [7:0] mdl_read(input int i);
        if (i >= NREG) return 8'h00;
        return mreg[i];
    endfunction

    task automatic mdl_write(input int i, input logic [7:0] v);
        if (i == 7 || i == 19 || i == 20 || i >= NREG) return;
        if (i == 11 || i == 13) begin
            mpend[(i-11)/2] = 1'b1; mstage[(i-11)/2] = v;
        end else if (i == 12 || i == 14) begin
            if (mpend[(i-12)/2]) begin
                mreg[i-1] = mstage[(i-12)/2]; mreg[i] = v;
            end
            mpend[(i-12)/2] = 1'b0;
        end else begin
            mreg[i] = v;
        end
    endtask

    function automatic logic [NREG*8-1:0] mdl_flat();
        logic [NREG*8-1:0] r;
        for (int i = 0; i < NREG; i++) r[i*8 +: 8] = mreg[i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Register file compared with the model on every clock (R3, R4, R5)
    always @(negedge clk) begin
        if (cmp_en) begin
            n_cmp++;
            if (cfg !== mdl_flat()) begin
                n_bad++;
                $display("FAIL R3 cfg_o actual=%0h expected=%0h", cfg, mdl_flat());
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
        mpend[0] = 1'b0; mpend[1] = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
        mpend[0] = 1'b0; mpend[1] = 1'b0;
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        b = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    // Sends one byte; widx >= 0 marks a data byte for the model
    task automatic send_byte(input logic [7:0] v, input int widx, output bit ack);
        logic a;
        cmp_en = 1'b0;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = ~a;
        if (ack && widx >= 0) mdl_write(widx, v);
        cmp_en = 1'b1;
    endtask

    task automatic recv_byte(input bit ack_it, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            v[i] = b;
        end
        put_bit(ack_it ? 1'b0 : 1'b1);
    endtask

    task automatic write_block(input int n);
        bit ack;
        bus_start();
        send_byte(8'hD2, -1, ack); chk(ack, "R11 address ack", ack, 1);
        send_byte(8'h5A, -1, ack); chk(ack, "R3 command ack", ack, 1);
        send_byte(8'hC3, -1, ack); chk(ack, "R3 count ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], i, ack);
            chk(ack, (i > 20) ? "R10 data ack" : "R3 data ack", ack, 1);
        end
        bus_stop();
    endtask

    task automatic read_block(input int n);
        bit ack;
        logic [7:0] v;
        int len;
        len = mreg[8];
        bus_start();
        send_byte(8'hD3, -1, ack); chk(ack, "R2 read address ack", ack, 1);
        recv_byte(n > 0, v); chk(v == len[7:0], "R6 length byte", v, len);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e;
            e = (k > len) ? 8'hFF : mdl_read(k);
            recv_byte(k < n-1, v);
            if (k == 7)      chk(v == e, "R7 id register", v, e);
            else if (k > 20) chk(v == e, "R10 past file", v, e);
            else             chk(v == e, "R6 read data", v, e);
        end
        bus_stop();
    endtask

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) wbuf[i] = 8'(seed + 37*i);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] v;
        mdl_init();
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk(cfg == mdl_flat(), "R1 reset values", 32'(cfg[8*9+7:0]), 32'(mdl_flat() & 'hFFFF));
        chk(sda_oe == 1'b0, "R1 bus released", sda_oe, 0);
        cmp_en = 1'b1;

        // R1 R6 R7: default readback of registers 0..8
        read_block(9);

        // R2: foreign write address with trailing bytes
        bus_start();
        send_byte(8'hD0, -1, ack); chk(!ack, "R2 foreign write address", ack, 0);
        send_byte(8'h00, -1, ack); chk(!ack, "R2 ignored byte", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD5, -1, ack); chk(!ack, "R2 foreign read address", ack, 0);
        bus_stop();

        // R3 R4: short block, stop after byte 5
        fill(6, 8'h11);
        write_block(6);
        read_block(9);

        // R5: block ending after reg 11, then after reg 13
        fill(12, 8'h40); wbuf[8] = 8'h14;
        write_block(12);
        fill(14, 8'h71); wbuf[8] = 8'h14;
        write_block(14);
        read_block(21);
        // R5 R7: full block with writes to 7, 19 and 20
        fill(21, 8'h09); wbuf[8] = 8'h14;
        write_block(21);
        read_block(21);

        // R10: writes past the file and length 23 (17h)
        fill(23, 8'h2B); wbuf[8] = 8'h17;
        write_block(23);
        read_block(25);   // last byte beyond L reads FFh (R6)

        // R8: stop in the middle of a data byte
        bus_start();
        send_byte(8'hD2, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h00, -1, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop();
        chk(cfg[7:0] == mreg[0], "R8 partial byte after stop", cfg[7:0], mreg[0]);

        // R8: repeated start in the middle of a byte, then read reg 0
        bus_start();
        send_byte(8'hD2, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'hE1, 0, ack);
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        bus_start();
        send_byte(8'hD3, -1, ack); chk(ack, "R8 address after restart", ack, 1);
        recv_byte(1'b1, v); chk(v == mreg[8], "R8 length after restart", v, mreg[8]);
        recv_byte(1'b0, v); chk(v == mreg[0], "R8 reg0 after restart", v, mreg[0]);
        // R9: bus stays released after the NACK
        for (int i = 0; i < 9; i++) begin
            logic b;
            get_bit(b);
            chk(b == 1'b1, "R9 released after NACK", b, 1);
        end
        bus_stop();

        // R9: recovery with a new read
        read_block(3);

        cmp_en = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule